// File: doc/BRIEF.md
# TLB Replacement Pointer and Lockdown Controller

This block chooses which slot of a small fully associative translation buffer is overwritten on each refill after a miss. It also tracks which slots hold live translations and which of them are locked against bulk invalidation. A 32-bit configuration word holds three fields: a lower bound for the replacement rotation, the next slot to overwrite, and a lock flag. Software writes and reads this word through a plain register port.

The refill path is a valid/ready stream. The walker raises `fill_valid`, and `fill_idx` always shows the slot that the next accepted refill will take. A refill is accepted on a rising edge where `fill_valid` and `fill_ready` are both high. When a refill is accepted, the slot is marked live and takes the current lock flag, and the pointer advances. The walker must hold `fill_valid` until a beat is accepted. `fill_ready` drops only during a cycle in which software writes the configuration word, because the register write takes priority.

A bulk-invalidate strobe clears every live slot that is not locked. The per-slot live and locked flags are outputs. Translation storage, tag matching and the walker itself lie outside this block.

Top module: `tlbv_ctrl`

## Requirements
- R1: After reset, the pointer, the lower bound and the lock flag are 0, all live and locked flags are 0, `cfg_rdata` is 0, `fill_idx` is 0 and `fill_ready` is 1.
- R2: On an accepted refill, slot `fill_idx` is live and its locked flag equals the lock flag after the edge. The pointer then moves to `fill_idx`+1.
- R3: When an accepted refill uses slot N-1, the pointer moves to the lower bound, not to 0.
- R4: With W = ceil(log2(N)), the configuration word carries the lower bound in bits [31:32-W], the pointer in bits [31-W:32-2W] and the lock flag in bit 0. A write loads all three fields. A read returns the lower bound, the lock flag and the current pointer. The bits between the pointer and bit 0 read as 0 and are ignored on write.
- R5: While `cfg_we` is 1, `fill_ready` is 0. A refill offered in that cycle writes no slot, and the pointer takes the written value.
- R6: `inv_all` clears the live flag of every slot whose locked flag is 0 and keeps locked slots live. A refill into a slot while the lock flag is 0 unlocks that slot.
- R7: With FIXED_BASE set, the lower bound is always 0, it reads back as 0, and the written lower-bound field is ignored.
- R8: If the pointer is written below the lower bound, it counts up through every slot to N-1 before the rotation is confined to lower bound..N-1.
- R9: A written lower-bound or pointer value of N or more is stored as N-1, and `fill_idx` is always below N.
- R10: If a refill and `inv_all` arrive in the same cycle, the refilled slot ends live. The other slots follow R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| fill_valid | input | 1 | Refill request from the walker |
| fill_ready | output | 1 | Refill can be accepted this cycle |
| fill_idx | output | IDX_W | Slot that the next accepted refill writes |
| inv_all | input | 1 | Bulk invalidate of unlocked slots |
| ent_valid | output | N_ENTRIES | Per-slot live flags |
| ent_prot | output | N_ENTRIES | Per-slot locked flags |

## Verification
`fill_idx` and `fill_ready` are combinational. They respond within the same cycle to the pointer and to `cfg_we`, so the bench samples them after driving the inputs and before the next rising edge. The live flags, locked flags and register readback change on the first rising edge after an accepted refill, a write or an invalidate. The bench drives every stimulus on a falling edge and compares these outputs at the following falling edge, exactly one edge later. A sweep over every lower-bound and pointer pair walks two full rotations for each pair and checks each refill index against an arithmetic model.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
  localparam int CFG_W = 32;

  function automatic int clamp_idx(input int raw, input int n_entries);
    return (raw >= n_entries) ? (n_entries - 1) : raw;
  endfunction
endpackage

// File: rtl/tlbv_lockreg.sv
module tlbv_lockreg #(
  parameter int N_ENTRIES  = 6,
  parameter bit FIXED_BASE = 1'b0,
  parameter int IDX_W      = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_base,
  input  logic [IDX_W-1:0] wr_victim,
  input  logic             wr_lock,
  input  logic             advance,
  output logic [IDX_W-1:0] base_q,
  output logic [IDX_W-1:0] victim_q,
  output logic             lock_q
);
  import tlbv_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] base_in, victim_in, victim_step;

  // Out-of-range writes are clamped to the last slot.
  assign victim_in   = IDX_W'(clamp_idx(int'(wr_victim), N_ENTRIES));
  assign victim_step = (victim_q == LAST) ? base_q : victim_q + IDX_W'(1);

  generate
    if (FIXED_BASE) begin : g_fixed
      assign base_in = '0;
      assign base_q  = '0;
    end else begin : g_prog
      logic [IDX_W-1:0] base_r;
      assign base_in = IDX_W'(clamp_idx(int'(wr_base), N_ENTRIES));
      always_ff @(posedge clk) begin
        if (!rst_n)     base_r <= '0;
        else if (wr_en) base_r <= base_in;
      end
      assign base_q = base_r;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_q <= '0;
      lock_q   <= 1'b0;
    end else if (wr_en) begin
      victim_q <= victim_in;
      lock_q   <= wr_lock;
    end else if (advance) begin
      victim_q <= victim_step;
    end
  end
endmodule

// File: rtl/tlbv_entry_flags.sv
module tlbv_entry_flags #(
  parameter int N_ENTRIES = 6,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_fire,
  input  logic [IDX_W-1:0]     fill_slot,
  input  logic                 fill_lock,
  input  logic                 inv_all,
  output logic [N_ENTRIES-1:0] live_q,
  output logic [N_ENTRIES-1:0] lock_q
);
  generate
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
      logic hit;
      assign hit = fill_fire && (fill_slot == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live_q[i] <= 1'b0;
          lock_q[i] <= 1'b0;
        end else if (hit) begin
          live_q[i] <= 1'b1;
          lock_q[i] <= fill_lock;
        end else if (inv_all && !lock_q[i]) begin
          live_q[i] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tlbv_ctrl.sv
module tlbv_ctrl #(
  parameter int N_ENTRIES  = 6,
  parameter bit FIXED_BASE = 1'b0,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  output logic [IDX_W-1:0]     fill_idx,
  input  logic                 inv_all,
  output logic [N_ENTRIES-1:0] ent_valid,
  output logic [N_ENTRIES-1:0] ent_prot
);
  localparam int BASE_LSB = 32 - IDX_W;
  localparam int VIC_LSB  = 32 - 2 * IDX_W;

  logic [IDX_W-1:0] base_q, victim_q;
  logic             lock_q, fire;

  assign fill_ready = !cfg_we;
  assign fire       = fill_valid && fill_ready;
  assign fill_idx   = victim_q;

  tlbv_lockreg #(.N_ENTRIES(N_ENTRIES), .FIXED_BASE(FIXED_BASE), .IDX_W(IDX_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_base   (cfg_wdata[BASE_LSB +: IDX_W]),
    .wr_victim (cfg_wdata[VIC_LSB +: IDX_W]),
    .wr_lock   (cfg_wdata[0]),
    .advance   (fire),
    .base_q    (base_q),
    .victim_q  (victim_q),
    .lock_q    (lock_q)
  );

  tlbv_entry_flags #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_fire (fire),
    .fill_slot (victim_q),
    .fill_lock (lock_q),
    .inv_all   (inv_all),
    .live_q    (ent_valid),
    .lock_q    (ent_prot)
  );

  always_comb begin
    cfg_rdata                        = '0;
    cfg_rdata[BASE_LSB +: IDX_W]     = base_q;
    cfg_rdata[VIC_LSB +: IDX_W]      = victim_q;
    cfg_rdata[0]                     = lock_q;
  end
endmodule

// File: rtl/tlbv_ctrl_chk.sv
module tlbv_ctrl_chk #(
  parameter int N_ENTRIES  = 6,
  parameter bit FIXED_BASE = 1'b0,
  parameter int IDX_W      = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [31:0]          cfg_rdata,
  input logic                 fill_valid,
  input logic                 fill_ready,
  input logic [IDX_W-1:0]     fill_idx,
  input logic                 inv_all,
  input logic [N_ENTRIES-1:0] ent_valid,
  input logic [N_ENTRIES-1:0] ent_prot
);
  localparam int BASE_LSB = 32 - IDX_W;
  localparam int VIC_LSB  = 32 - 2 * IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic fire;
  logic [IDX_W-1:0] rd_base, rd_vic;
  assign fire    = fill_valid && fill_ready;
  assign rd_base = cfg_rdata[BASE_LSB +: IDX_W];
  assign rd_vic  = cfg_rdata[VIC_LSB +: IDX_W];

  assert_write_blocks_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !fill_ready);

  assert_slot_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ent_valid[$past(fill_idx)]);

  assert_pointer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rd_vic == (($past(fill_idx) == LAST) ? $past(rd_base) : $past(fill_idx) + IDX_W'(1)));

  assert_idle_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !cfg_we) |=> $stable(fill_idx));

  assert_inv_keeps_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fire) |=> ent_valid == $past(ent_valid & ent_prot));

  assert_locked_is_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_prot & ~ent_valid) == '0);

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[VIC_LSB-1:1] == '0);

  assert_fixed_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    FIXED_BASE |-> rd_base == '0);

  assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_idx) < N_ENTRIES);
endmodule

bind tlbv_ctrl tlbv_ctrl_chk #(.N_ENTRIES(N_ENTRIES), .FIXED_BASE(FIXED_BASE), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_rdata  (cfg_rdata),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .fill_idx   (fill_idx),
  .inv_all    (inv_all),
  .ent_valid  (ent_valid),
  .ent_prot   (ent_prot)
);

// File: tb/sim_tlbv_ctrl.sv
`timescale 1ns/1ps
module sim_tlbv_ctrl;
  localparam int N  = 6;
  localparam int W  = 3;
  localparam int BL = 32 - W;
  localparam int VL = 32 - 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 0, fill_valid = 0, inv_all = 0;
  logic [31:0]   cfg_wdata = 0, cfg_rdata;
  logic          fill_ready;
  logic [W-1:0]  fill_idx;
  logic [N-1:0]  ent_valid, ent_prot;

  logic          f_we = 0, f_fv = 0, f_inv = 0;
  logic [31:0]   f_wd = 0, f_rd;
  logic          f_rdy;
  logic [W-1:0]  f_idx;
  logic [N-1:0]  f_val, f_prot;

  tlbv_ctrl #(.N_ENTRIES(N), .FIXED_BASE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_idx(fill_idx), .inv_all(inv_all),
    .ent_valid(ent_valid), .ent_prot(ent_prot));

  tlbv_ctrl #(.N_ENTRIES(N), .FIXED_BASE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(f_we), .cfg_wdata(f_wd), .cfg_rdata(f_rd),
    .fill_valid(f_fv), .fill_ready(f_rdy), .fill_idx(f_idx), .inv_all(f_inv),
    .ent_valid(f_val), .ent_prot(f_prot));

  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [31:0] word(int b, int v, int p);
    return (32'(b) << BL) | (32'(v) << VL) | 32'(p);
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cfg_we = 0; fill_valid = 0; inv_all = 0;
    f_we = 0; f_fv = 0; f_inv = 0;
  endtask

  task automatic wr0(int b, int v, int p);
    cfg_we = 1; cfg_wdata = word(b, v, p) | 32'h0000_0ff6; // reserved bits set
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ev;
    int bv, vv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rdata", cfg_rdata, 0);
    check("R1 valid", ent_valid, 0);
    check("R1 prot", ent_prot, 0);
    check("R1 idx", fill_idx, 0);
    check("R1 ready", fill_ready, 1);
    check("R1 fixed rdata", f_rd, 0);

    // R2 R3 R4 R8 sweep every base/pointer pair
    ev = '0;
    for (int b = 0; b < N; b++) begin
      for (int v = 0; v < N; v++) begin
        wr0(b, v, 0);
        check("R4 readback", cfg_rdata, word(b, v, 0));
        bv = b; vv = v;
        for (int k = 0; k < 2 * N; k++) begin
          check("R2 fill_idx", fill_idx, vv);
          fill_valid = 1;
          ev[vv] = 1'b1;
          tick();
          vv = (vv == N - 1) ? bv : vv + 1;
          check("R2 live", ent_valid, ev);
          check("R3 R8 pointer", cfg_rdata, word(bv, vv, 0));
        end
      end
    end

    // R6 unlocked slots cleared
    inv_all = 1; tick();
    check("R6 inv clears", ent_valid, 0);

    // R6 lock two slots, then three unlocked
    wr0(0, 0, 1);
    fill_valid = 1; tick();
    fill_valid = 1; tick();
    check("R6 locked", ent_prot, 6'b000011);
    wr0(0, 2, 0);
    fill_valid = 1; tick();
    fill_valid = 1; tick();
    fill_valid = 1; tick();
    check("R6 live", ent_valid, 6'b011111);
    inv_all = 1; tick();
    check("R6 inv keeps locked", ent_valid, 6'b000011);
    check("R6 prot kept", ent_prot, 6'b000011);

    // R5 write wins over refill
    cfg_we = 1; cfg_wdata = word(0, 5, 0); fill_valid = 1;
    #1 check("R5 ready low", fill_ready, 0);
    tick();
    check("R5 no slot written", ent_valid, 6'b000011);
    check("R5 pointer from write", cfg_rdata, word(0, 5, 0));

    // R10 refill and invalidate together
    fill_valid = 1; inv_all = 1; tick();
    check("R10 refilled stays", ent_valid, 6'b100011);
    check("R10 wrapped", fill_idx, 0);

    // R6 unlocked refill over locked slot clears lock
    fill_valid = 1; tick();
    check("R6 relock cleared", ent_prot, 6'b000010);

    // R9 clamping
    wr0(7, 6, 0);
    check("R9 clamp", cfg_rdata, word(5, 5, 0));
    check("R9 idx", fill_idx, 5);
    fill_valid = 1; tick();
    check("R9 wrap to clamped base", fill_idx, 5);

    // R7 fixed lower bound
    f_we = 1; f_wd = word(3, 4, 1); tick();
    check("R7 base ignored", f_rd, word(0, 4, 1));
    for (int k = 0; k < 4; k++) begin
      check("R7 fill_idx", f_idx, (4 + k) % N);
      f_fv = 1; tick();
    end
    check("R7 live", f_val, 6'b110011);
    check("R7 locked", f_prot, 6'b110011);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule